// File: doc/BRIEF.md
# Postfix Stack Evaluator

This block evaluates an arithmetic expression already converted to postfix order. Bytes arrive one at a time on a valid-qualified input. Each operand byte is pushed onto an operand stack of 32-bit words. Each operator byte takes the two newest words off the stack and hands them to a small arithmetic unit. The unit's result is then pushed back in their place. The expression is read once, front to back, and no entry is ever moved once it is stored.

A pulse on `start_i` opens a new expression. The terminator byte closes it. If exactly one word is left on the stack at that point, the block presents that word on `result_o` together with a one-cycle `result_valid_o`. Two sticky flags report problems. `error_o` signals a malformed expression. `underflow_o` signals that a subtraction went below zero.

The arithmetic unit is selected by a 3-bit code. Add, subtract and multiply finish in one cycle. Power is computed by repeated multiplication, so its run time depends on the exponent. While an operator is being computed the block does not accept new bytes, and the source has to pace itself to match.

Top module: `postfix_eval`

## Requirements
- R1: After reset, `result_o` is 0 and `result_valid_o`, `error_o` and `underflow_o` are all low.
- R2: A byte from 0x00 to 0x7F is an operand. It is pushed as a 32-bit word, zero-extended.
- R3: A byte from 0x80 to 0x83 is an operator, and its low three bits select the operation: 000 add, 001 subtract, 010 multiply, 011 power. The second-popped word is the left operand of subtract and the base of power. The first-popped word is the right operand and the exponent. The two words are replaced by one result, taken modulo 2^32.
- R4: Power is computed by repeated multiplication, one multiply per cycle. An exponent of 0 gives 1, including for a base of 0.
- R5: When the terminator 0xFF arrives with exactly one word on the stack and no error recorded, `result_o` takes that word and `result_valid_o` is high for exactly one cycle. `result_o` then holds until the next start.
- R6: `error_o` is set, with no result pulse, in three cases: the terminator arrives with a stack depth other than one, an operator arrives with fewer than two words on the stack, or an operand arrives on a full stack. The flag stays set until the next start.
- R7: A subtraction whose left operand is smaller than its right operand wraps modulo 2^32 and sets `underflow_o`. The flag stays set until the next start.
- R8: A byte is ignored in any of these cases: it arrives before the first start, it arrives while an operator is being computed, it arrives after the terminator, or its value lies in 0x84 to 0xFE.
- R9: `start_i` empties the stack, clears `result_o` to 0 and clears both flags, and the next byte begins a new expression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new expression |
| byte_i | input | 8 | Postfix byte |
| byte_valid_i | input | 1 | `byte_i` is valid this cycle |
| result_o | output | 32 | Evaluated result |
| result_valid_o | output | 1 | One-cycle pulse when `result_o` is updated |
| error_o | output | 1 | Sticky malformed-expression flag |
| underflow_o | output | 1 | Sticky negative-subtraction flag |

## Verification
The expressions used are chosen so that each one separates a different way the evaluator could go wrong:

- **Single operators:** a lone multiply and a lone add show that the select codes are decoded correctly.
- **Operand order:** a subtraction run both ways round shows that the left and right operands are not swapped, and that underflow is detected on the negative case.
- **Power edge cases:** exponents of 0, 31, 32 and 127, and a base of 0, show both the loop-termination case and the wrap modulo 2^32.
- **Nesting:** a nested expression that should give 50, and a chained power, show that partial results are pushed back onto the stack and reused.
- **Malformed input:** short stacks, leftover operands and an overflowing stack separate the three error causes from valid results.
- **Ignored bytes:** filler bytes, bytes sent before the first start, bytes sent after the terminator, and a byte sent in the middle of a power computation show that none of them change the stack.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    ALU_ADD = 3'b000,
    ALU_SUB = 3'b001,
    ALU_MUL = 3'b010,
    ALU_POW = 3'b011
  } alu_sel_e;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_CALC, S_DONE} ctl_state_e;

  localparam logic [7:0] TERM_BYTE = 8'hFF;
  localparam logic [7:0] OPR_FIRST = 8'h80;
  localparam logic [7:0] OPR_LAST  = 8'h83;
endpackage

// File: rtl/pe_stack.sv
module pe_stack #(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 32,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop2_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] top_o,
  output logic [WIDTH-1:0] second_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o
);
  logic [WIDTH-1:0] ent_q [DEPTH];
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    idx1, idx2;

  assign idx1 = cnt_q - CW'(1);
  assign idx2 = cnt_q - CW'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (push_i && cnt_q < CW'(DEPTH)) begin
      ent_q[cnt_q[IW-1:0]] <= wdata_i;
      cnt_q <= cnt_q + CW'(1);
    end else if (pop2_i && cnt_q >= CW'(2)) begin
      cnt_q <= cnt_q - CW'(2);
    end
  end

  assign top_o    = (cnt_q >= CW'(1)) ? ent_q[idx1[IW-1:0]] : '0;
  assign second_o = (cnt_q >= CW'(2)) ? ent_q[idx2[IW-1:0]] : '0;
  assign count_o  = cnt_q;
  assign full_o   = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/pe_alu.sv
module pe_alu
  import pe_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  alu_sel_e         sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o,
  output logic             valid_o,
  output logic             uflow_o
);
  logic             busy_q;
  logic [WIDTH-1:0] acc_q, base_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o     <= '0;
      valid_o <= 1'b0;
      uflow_o <= 1'b0;
      busy_q  <= 1'b0;
      acc_q   <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else begin
      valid_o <= 1'b0;
      uflow_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b0;
        unique case (sel_i)
          ALU_ADD: begin y_o <= a_i + b_i; valid_o <= 1'b1; end
          ALU_SUB: begin
            y_o     <= a_i - b_i;
            uflow_o <= (a_i < b_i);
            valid_o <= 1'b1;
          end
          ALU_MUL: begin y_o <= a_i * b_i; valid_o <= 1'b1; end
          default: begin
            acc_q  <= WIDTH'(1);
            base_q <= a_i;
            cnt_q  <= b_i;
            busy_q <= 1'b1;
          end
        endcase
      end else if (busy_q) begin
        // one multiply per cycle until the exponent is spent
        if (cnt_q == '0) begin
          y_o     <= acc_q;
          valid_o <= 1'b1;
          busy_q  <= 1'b0;
        end else begin
          acc_q <= acc_q * base_q;
          cnt_q <= cnt_q - WIDTH'(1);
        end
      end
    end
  end
endmodule

// File: rtl/postfix_eval.sv
module postfix_eval
  import pe_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 32,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic [WIDTH-1:0] result_o,
  output logic             result_valid_o,
  output logic             error_o,
  output logic             underflow_o
);
  ctl_state_e       state_q;
  logic [WIDTH-1:0] top, second, alu_y, wdata;
  logic [CW-1:0]    count;
  logic             full, alu_valid, alu_uflow;
  logic             accept, is_opd, is_opr, is_term;
  logic             do_push, do_op;

  assign is_opd  = ~byte_i[7];
  assign is_opr  = (byte_i >= OPR_FIRST) && (byte_i <= OPR_LAST);
  assign is_term = (byte_i == TERM_BYTE);
  assign accept  = byte_valid_i && (state_q == S_RUN) && !start_i;
  assign do_op   = accept && is_opr && (count >= CW'(2));
  assign do_push = (accept && is_opd && !full) ||
                   (state_q == S_CALC && alu_valid && !start_i);
  assign wdata   = (state_q == S_CALC) ? alu_y : {{(WIDTH-8){1'b0}}, byte_i};

  pe_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_stack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_i),
    .push_i   (do_push),
    .pop2_i   (do_op),
    .wdata_i  (wdata),
    .top_o    (top),
    .second_o (second),
    .count_o  (count),
    .full_o   (full)
  );

  pe_alu #(.WIDTH(WIDTH)) u_alu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (do_op),
    .sel_i   (alu_sel_e'(byte_i[2:0])),
    .a_i     (second),
    .b_i     (top),
    .y_o     (alu_y),
    .valid_o (alu_valid),
    .uflow_o (alu_uflow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= S_IDLE;
      result_o       <= '0;
      result_valid_o <= 1'b0;
      error_o        <= 1'b0;
      underflow_o    <= 1'b0;
    end else if (start_i) begin
      state_q        <= S_RUN;
      result_o       <= '0;
      result_valid_o <= 1'b0;
      error_o        <= 1'b0;
      underflow_o    <= 1'b0;
    end else begin
      result_valid_o <= 1'b0;
      unique case (state_q)
        S_RUN: if (accept) begin
          if (is_opd && full) error_o <= 1'b1;
          if (is_opr && count < CW'(2)) error_o <= 1'b1;
          if (do_op) state_q <= S_CALC;
          if (is_term) begin
            if (count == CW'(1) && !error_o) begin
              result_o       <= top;
              result_valid_o <= 1'b1;
            end else begin
              error_o <= 1'b1;
            end
            state_q <= S_DONE;
          end
        end
        S_CALC: if (alu_valid) begin
          if (alu_uflow) underflow_o <= 1'b1;
          state_q <= S_RUN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] result_o,
  input logic             result_valid_o,
  input logic             error_o,
  input logic             underflow_o
);
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  a_r5_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (result_valid_o || $stable(result_o)));

  a_r6_no_pulse_on_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> !error_o);

  a_r6_error_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> error_o);

  a_r7_uflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !start_i) |=> underflow_o);

  a_r9_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (result_o == '0 && !error_o && !underflow_o && !result_valid_o));
endmodule

bind postfix_eval pe_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .result_o       (result_o),
  .result_valid_o (result_valid_o),
  .error_o        (error_o),
  .underflow_o    (underflow_o)
);

// File: tb/sim_postfix_eval.sv
module sim_postfix_eval;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  // bytes left-aligned, first byte in bits 63:56
  localparam logic [63:0] V_BYTES [NV] = '{
    64'h020382FF_FFFFFFFF,
    64'h05060202_838082FF,
    64'h070381FF_FFFFFFFF,
    64'h030781FF_FFFFFFFF,
    64'h020083FF_FFFFFFFF,
    64'h000083FF_FFFFFFFF,
    64'h021F83FF_FFFFFFFF,
    64'h022083FF_FFFFFFFF,
    64'h7F7F827F_82FFFFFF,
    64'h7F7F80FF_FFFFFFFF,
    64'h0A90FFFF_FFFFFFFF,
    64'h0304FFFF_FFFFFFFF,
    64'h0580FFFF_FFFFFFFF,
    64'h02038302_83FFFFFF,
    64'h017F83FF_FFFFFFFF
  };
  localparam logic [31:0] V_RES [NV] = '{
    32'd6, 32'd50, 32'd4, 32'hFFFF_FFFC, 32'd1, 32'd1, 32'h8000_0000,
    32'd0, 32'h001F_417F, 32'hFE, 32'hA, 32'd0, 32'd0, 32'h40, 32'd1
  };
  localparam logic [NV-1:0] V_PULSE = 15'b110_0111_1111_1111;
  localparam logic [NV-1:0] V_ERR   = 15'b001_1000_0000_0000;
  localparam logic [NV-1:0] V_UF    = 15'b000_0000_0000_1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        byte_valid_i = 1'b0;
  logic [31:0] result_o;
  logic        result_valid_o, error_o, underflow_o;

  int n_chk = 0;
  int n_err = 0;
  int pulses = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  postfix_eval u0 (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .byte_i         (byte_i),
    .byte_valid_i   (byte_valid_i),
    .result_o       (result_o),
    .result_valid_o (result_valid_o),
    .error_o        (error_o),
    .underflow_o    (underflow_o)
  );

  always @(posedge clk_i) if (result_valid_o) pulses = pulses + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    pulses = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk_i);
    byte_i = b;
    byte_valid_i = 1'b1;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
    if (b >= 8'h80 && b <= 8'h83) repeat (150) @(negedge clk_i);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic run_expr(input logic [63:0] bytes);
    pulse_start();
    for (int k = 0; k < 8; k++) begin
      logic [7:0] b;
      b = bytes[63 - 8*k -: 8];
      send(b);
      if (b == 8'hFF) break;
    end
    settle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 result", result_o, 32'd0);
    chk("R1 valid", {31'd0, result_valid_o}, 32'd0);
    chk("R1 error", {31'd0, error_o}, 32'd0);
    chk("R1 underflow", {31'd0, underflow_o}, 32'd0);
    rst_ni = 1'b1;

    // R8 bytes before the first start are ignored
    pulses = 0;
    send(8'h05);
    send(8'hFF);
    settle();
    chk("R8 pre-start pulses", pulses, 0);
    chk("R8 pre-start result", result_o, 32'd0);
    chk("R8 pre-start error", {31'd0, error_o}, 32'd0);

    // R2 R3 R4 R5 R6 R7 R8 table of expressions
    for (int v = 0; v < NV; v++) begin
      run_expr(V_BYTES[v]);
      chk($sformatf("R5 vec%0d pulses", v), pulses, {31'd0, V_PULSE[v]});
      chk($sformatf("R3 vec%0d result", v), result_o, V_RES[v]);
      chk($sformatf("R6 vec%0d error", v), {31'd0, error_o}, {31'd0, V_ERR[v]});
      chk($sformatf("R7 vec%0d underflow", v), {31'd0, underflow_o}, {31'd0, V_UF[v]});
    end

    // R8 bytes after the terminator are ignored, result held (R5)
    pulses = 0;
    send(8'h09);
    send(8'hFF);
    settle();
    chk("R8 post-term pulses", pulses, 0);
    chk("R5 post-term hold", result_o, 32'd1);
    chk("R8 post-term error", {31'd0, error_o}, 32'd0);

    // R8 byte arriving during a power computation is dropped
    pulse_start();
    send(8'h02);
    send(8'h05);
    @(negedge clk_i) begin byte_i = 8'h83; byte_valid_i = 1'b1; end
    @(negedge clk_i) byte_i = 8'h03;
    @(negedge clk_i) byte_valid_i = 1'b0;
    repeat (20) @(negedge clk_i);
    send(8'hFF);
    settle();
    chk("R8 busy drop result", result_o, 32'd32);
    chk("R8 busy drop error", {31'd0, error_o}, 32'd0);
    chk("R4 busy drop pulses", pulses, 1);

    // R6 operand pushed on a full stack
    pulse_start();
    for (int i = 0; i < 17; i++) send(8'h01);
    send(8'hFF);
    settle();
    chk("R6 overflow error", {31'd0, error_o}, 32'd1);
    chk("R6 overflow pulses", pulses, 0);

    // R9 start clears flags and result
    run_expr(V_BYTES[3]);
    chk("R7 before clear", {31'd0, underflow_o}, 32'd1);
    pulse_start();
    chk("R9 underflow cleared", {31'd0, underflow_o}, 32'd0);
    chk("R9 result cleared", result_o, 32'd0);
    chk("R9 error cleared", {31'd0, error_o}, 32'd0);
    send(8'h04);
    send(8'hFF);
    settle();
    chk("R9 fresh expression", result_o, 32'd4);

    finish_run();
  end
endmodule